// File: doc/BRIEF.md
# AHB-Lite Transaction Master Bridge

This block turns one-shot transaction requests from a processor into AHB-Lite master signalling on a bus that has only one master. The processor presents a direction, a start address, a transfer size, a burst selector, a beat count and a write word, and then pulses a start strobe for one cycle. The bridge drives the address phases and then the data phases on the bus. It steps the address by the transfer width on every beat and overlaps each address phase with the data phase of the beat before it. It signals completion with a one-cycle pulse.

Because the bus has a single master, no request or grant handshake takes place, and the bridge starts a transaction as soon as it is idle. Slave wait states (HREADY low) freeze the whole pipeline. Read beats update a read-data register that the processor can sample. Every write beat of a transaction carries the single word given at the start.

Top module: `ahbl_master_bridge`

## Requirements
- R1: After reset, htrans is IDLE (2'b00), reqDone is low, and haddr, hwdata and rdData are zero.
- R2: With reqBurst = 0, exactly one transfer is issued whatever reqBeats holds, and hburst is SINGLE (3'b000).
- R3: With reqBurst = 1, reqBeats transfers are issued, and a count of 0 is treated as 1. hburst is 3'b011 for 4 beats, 3'b101 for 8 beats, 3'b111 for 16 beats, and INCR (3'b001) for any other count.
- R4: htrans is NONSEQ (2'b10) on the first beat and SEQ (2'b11) on each later beat. It returns to IDLE once the last address phase is accepted.
- R5: hsize equals reqSize (0 byte, 1 halfword, 2 word), and beat k uses address reqAddr + k * 2^reqSize.
- R6: With HREADY held high, the address of each new beat is issued in the same cycle as the data phase of the previous beat. reqDone is seen N+1 cycles after the first NONSEQ cycle of an N-beat transaction.
- R7: During the data phase of each write beat, one cycle after its address phase, hwdata carries the word given at start.
- R8: While HREADY is low, haddr, htrans, hsize and hwdata hold their values and the beat sequence does not advance.
- R9: At the end of each read data phase with HREADY high, rdData captures hrdata and then holds it until the next read beat.
- R10: reqDone is high for exactly one cycle: the cycle after the final data phase completes with HREADY high.
- R11: A start strobe that arrives while a transaction is in flight has no effect on the addresses issued or on the number of completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqStart | input | 1 | One-cycle start strobe from the processor |
| reqWrite | input | 1 | 1 = write transaction, 0 = read |
| reqAddr | input | ADDR_W | Start address |
| reqSize | input | 3 | Transfer size code (bytes = 2^code) |
| reqBurst | input | 1 | 0 = single transfer, 1 = incrementing burst |
| reqBeats | input | BEAT_W | Beat count for a burst |
| reqWdata | input | DATA_W | Word written on every write beat |
| rdData | output | DATA_W | Last captured read word |
| reqDone | output | 1 | One-cycle completion pulse |
| haddr | output | ADDR_W | Bus address |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Bus transfer size |
| hburst | output | 3 | Bus burst type |
| htrans | output | 2 | Bus transfer type |
| hwdata | output | DATA_W | Bus write data |
| hready | input | 1 | Bus ready from the slave |
| hrdata | input | DATA_W | Bus read data from the slave |

## Verification
The critical overlap is between two things that happen on the same clock edge: one beat's data phase completes, which means write data is consumed or hrdata is captured, and the next beat's address phase is accepted. The bench runs a bus-slave model that completes data phases at full rate and also under an irregular HREADY pattern, so stalls land at every position within bursts of 1 to 16 beats. At each edge it checks the pair against arithmetic expectations: the completed beat's data and the address, HTRANS code and control of the beat just accepted. The address-step and hold properties in the checker confirm that a stall freezes both halves together.

// File: rtl/ahbl_bridge_pkg.sv
package ahbl_bridge_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } transType_e;

  localparam logic [2:0] BURST_SINGLE = 3'b000;
  localparam logic [2:0] BURST_INCR   = 3'b001;
  localparam logic [2:0] BURST_INCR4  = 3'b011;
  localparam logic [2:0] BURST_INCR8  = 3'b101;
  localparam logic [2:0] BURST_INCR16 = 3'b111;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // new transaction accepted
    logic accept;   // current address phase accepted this edge
    logic advance;  // accepted and another beat follows
    logic capture;  // a data phase completes this edge
  } ctrlStrobe_t;

endpackage

// File: rtl/ahbl_bridge_ctrl.sv
module ahbl_bridge_ctrl
  import ahbl_bridge_pkg::*;
#(
  parameter int BEAT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic              reqBurst,
  input  logic [BEAT_W-1:0] reqBeats,
  input  logic              hready,
  output logic [1:0]        htrans,
  output logic              reqDone,
  output ctrlStrobe_t       stb
);

  localparam logic [BEAT_W-1:0] ONE_BEAT = BEAT_W'(1);

  transType_e        transQ;
  logic [BEAT_W-1:0] issueLeft;
  logic              dataPhase;
  logic              dataLast;
  logic              busy;
  logic              startOk;
  logic              apAccept;
  logic              dpComplete;
  logic [BEAT_W-1:0] beatsEff;

  assign busy       = (transQ != TR_IDLE) || dataPhase;
  assign startOk    = reqStart && !busy;
  assign apAccept   = hready && (transQ != TR_IDLE);
  assign dpComplete = hready && dataPhase;
  assign beatsEff   = (!reqBurst || reqBeats == '0) ? ONE_BEAT : reqBeats;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      transQ    <= TR_IDLE;
      issueLeft <= '0;
    end else if (startOk) begin
      transQ    <= TR_NONSEQ;
      issueLeft <= beatsEff - ONE_BEAT;
    end else if (apAccept) begin
      if (issueLeft != '0) begin
        transQ    <= TR_SEQ;
        issueLeft <= issueLeft - ONE_BEAT;
      end else begin
        transQ <= TR_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataPhase <= 1'b0;
      dataLast  <= 1'b0;
    end else if (apAccept) begin
      dataPhase <= 1'b1;
      dataLast  <= (issueLeft == '0);
    end else if (dpComplete) begin
      dataPhase <= 1'b0;
      dataLast  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqDone <= 1'b0;
    else       reqDone <= dpComplete && dataLast;
  end

  always_comb begin
    stb.load    = startOk;
    stb.accept  = apAccept;
    stb.advance = apAccept && (issueLeft != '0);
    stb.capture = dpComplete;
  end

  assign htrans = transQ;

endmodule

// File: rtl/ahbl_bridge_dp.sv
module ahbl_bridge_dp
  import ahbl_bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic              reqBurst,
  input  logic [BEAT_W-1:0] reqBeats,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] hrdata,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] wdHold;
  logic [ADDR_W-1:0] addrStep;
  logic [2:0]        burstCode;

  assign addrStep = ADDR_W'(1) << hsize;

  always_comb begin
    if (!reqBurst) begin
      burstCode = BURST_SINGLE;
    end else begin
      case (32'(reqBeats))
        4:       burstCode = BURST_INCR4;
        8:       burstCode = BURST_INCR8;
        16:      burstCode = BURST_INCR16;
        default: burstCode = BURST_INCR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haddr  <= '0;
      hwrite <= 1'b0;
      hsize  <= '0;
      hburst <= BURST_SINGLE;
      wdHold <= '0;
    end else if (stb.load) begin
      haddr  <= reqAddr;
      hwrite <= reqWrite;
      hsize  <= reqSize;
      hburst <= burstCode;
      wdHold <= reqWdata;
    end else if (stb.advance) begin
      haddr <= haddr + addrStep;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      hwdata <= '0;
    else if (stb.accept && hwrite)  hwdata <= wdHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      rdData <= '0;
    else if (stb.capture && !hwrite) rdData <= hrdata;
  end

endmodule

// File: rtl/ahbl_master_bridge.sv
module ahbl_master_bridge
  import ahbl_bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic              reqBurst,
  input  logic [BEAT_W-1:0] reqBeats,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              reqDone,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [1:0]        htrans,
  output logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  input  logic [DATA_W-1:0] hrdata
);

  ctrlStrobe_t stb;

  ahbl_bridge_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqStart (reqStart),
    .reqBurst (reqBurst),
    .reqBeats (reqBeats),
    .hready   (hready),
    .htrans   (htrans),
    .reqDone  (reqDone),
    .stb      (stb)
  );

  ahbl_bridge_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqBurst (reqBurst),
    .reqBeats (reqBeats),
    .reqWdata (reqWdata),
    .hrdata   (hrdata),
    .haddr    (haddr),
    .hwrite   (hwrite),
    .hsize    (hsize),
    .hburst   (hburst),
    .hwdata   (hwdata),
    .rdData   (rdData)
  );

endmodule

// File: rtl/ahbl_master_bridge_chk.sv
module ahbl_master_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] haddr,
  input logic [2:0]        hsize,
  input logic [2:0]        hburst,
  input logic [1:0]        htrans,
  input logic [DATA_W-1:0] hwdata,
  input logic              hready,
  input logic              reqDone
);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (htrans != 2'b00 && !hready) |=> ($stable(haddr) && $stable(htrans) && $stable(hsize)));

  // R8
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hready |=> $stable(hwdata));

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b11 && $past(hready)) |-> (haddr == $past(haddr) + (ADDR_W'(1) << hsize)));

  // R4
  seq_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b11) |-> (hburst != 3'b000));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> (htrans == 2'b00));

endmodule

bind ahbl_master_bridge ahbl_master_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .haddr   (haddr),
  .hsize   (hsize),
  .hburst  (hburst),
  .htrans  (htrans),
  .hwdata  (hwdata),
  .hready  (hready),
  .reqDone (reqDone)
);

// File: tb/ahbl_master_bridge_tb.sv
`timescale 1ns/1ps
module ahbl_master_bridge_tb;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqStart = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [2:0]    reqSize = '0;
  logic          reqBurst = 1'b0;
  logic [BW-1:0] reqBeats = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [DW-1:0] rdData;
  logic          reqDone;
  logic [AW-1:0] haddr;
  logic          hwrite;
  logic [2:0]    hsize;
  logic [2:0]    hburst;
  logic [1:0]    htrans;
  logic [DW-1:0] hwdata;
  logic          hready = 1'b1;
  logic [DW-1:0] hrdata;

  always #2.5 clk = ~clk;

  ahbl_master_bridge #(.ADDR_W(AW), .DATA_W(DW), .BEAT_W(BW)) u_dut (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqBurst(reqBurst),
    .reqBeats(reqBeats), .reqWdata(reqWdata), .rdData(rdData),
    .reqDone(reqDone), .haddr(haddr), .hwrite(hwrite), .hsize(hsize),
    .hburst(hburst), .htrans(htrans), .hwdata(hwdata), .hready(hready),
    .hrdata(hrdata)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rdPattern(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  // slave model: tracks the data phase
  logic          dpValid = 1'b0;
  logic          dpWrite = 1'b0;
  logic [AW-1:0] dpAddr = '0;
  always_ff @(posedge clk) begin
    if (hready) begin
      dpValid <= htrans[1];
      dpAddr  <= haddr;
      dpWrite <= hwrite;
    end
  end
  assign hrdata = rdPattern(dpAddr);

  // HREADY driver
  bit waitMode = 0;
  int rdyCnt = 0;
  initial begin
    forever begin
      @(posedge clk);
      #1;
      rdyCnt++;
      if (dpValid && waitMode) hready = !((rdyCnt % 3) == 1 || (rdyCnt % 5) == 0);
      else                     hready = 1'b1;
    end
  end

  // expectations for the current transaction
  bit            inTxn = 0;
  int            apIdx = 0;
  int            dpIdx = 0;
  int            expBeats = 1;
  logic [AW-1:0] base = '0;
  int            step = 1;
  logic [2:0]    expSize = '0;
  logic [2:0]    expBurst = '0;
  bit            expWrite = 0;
  logic [DW-1:0] expWdata = '0;
  bit            doneDue = 0;
  int            cyc = 0;
  bit            pendRd = 0;
  logic [DW-1:0] pendVal = '0;
  bit            stallPrev = 0;
  logic [AW-1:0] prevAddr = '0;
  logic [1:0]    prevTrans = '0;
  logic [DW-1:0] prevWd = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (pendRd) begin
        chk(rdData == pendVal, "R9", rdData, pendVal);
        pendRd = 0;
      end
      if (doneDue) begin
        chk(reqDone == 1'b1, "R10", reqDone, 1);
        if (!waitMode) chk(cyc == expBeats + 1, "R6", cyc, expBeats + 1);
        chk(dpIdx == expBeats, "R3", dpIdx, expBeats);
        chk(htrans == 2'b00, "R4", htrans, 0);
        doneDue = 0;
        inTxn = 0;
      end else if (reqDone) begin
        chk(0, "R10", reqDone, 0);
      end
      if (stallPrev) begin
        chk(haddr == prevAddr && htrans == prevTrans, "R8", haddr, prevAddr);
        chk(hwdata == prevWd, "R8", hwdata, prevWd);
      end
      // data phase completing at the coming edge
      if (dpValid && hready) begin
        if (!inTxn) chk(0, "R11", dpIdx, expBeats);
        if (expWrite) chk(hwdata == expWdata, "R7", hwdata, expWdata);
        else begin
          pendRd = 1;
          pendVal = rdPattern(dpAddr);
        end
        dpIdx++;
        if (dpIdx == expBeats) doneDue = 1;
      end
      // address phase accepted at the coming edge
      if (htrans != 2'b00 && hready) begin
        logic [AW-1:0] ea;
        ea = base + AW'(apIdx * step);
        if (apIdx == 0) cyc = 0;
        if (apIdx >= expBeats) chk(0, "R2", apIdx, expBeats);
        chk(htrans == (apIdx == 0 ? 2'b10 : 2'b11), "R4", htrans, (apIdx == 0 ? 2 : 3));
        chk(haddr == ea, "R5", haddr, ea);
        chk(hsize == expSize, "R5", hsize, expSize);
        chk(hburst == expBurst, (expBurst == 3'b000) ? "R2" : "R3", hburst, expBurst);
        chk(hwrite == expWrite, "R5", hwrite, expWrite);
        apIdx++;
      end
      stallPrev = (!hready && (htrans != 2'b00 || dpValid));
      prevAddr  = haddr;
      prevTrans = htrans;
      prevWd    = hwdata;
      cyc++;
    end
  end

  task automatic runTxn(input bit wr, input logic [AW-1:0] addr, input int size,
                        input bit burst, input int beats, input logic [DW-1:0] wd,
                        input bit restart);
    int n;
    expBeats = (!burst || beats == 0) ? 1 : beats;
    base     = addr;
    step     = 1 << size;
    expSize  = 3'(size);
    expBurst = !burst ? 3'b000 : (beats == 4 ? 3'b011 : beats == 8 ? 3'b101 :
                                  beats == 16 ? 3'b111 : 3'b001);
    expWrite = wr;
    expWdata = wd;
    apIdx = 0;
    dpIdx = 0;
    inTxn = 1;
    @(posedge clk); #1;
    reqWrite = wr; reqAddr = addr; reqSize = 3'(size); reqBurst = burst;
    reqBeats = BW'(beats); reqWdata = wd; reqStart = 1'b1;
    @(posedge clk); #1;
    reqStart = 1'b0;
    if (restart) begin
      // R11: second strobe mid-transaction with other fields
      reqAddr = addr + 32'h400; reqWrite = !wr; reqWdata = ~wd; reqBeats = 5'd2;
      reqStart = 1'b1;
      @(posedge clk); #1;
      reqStart = 1'b0;
    end
    n = 0;
    while (inTxn && n < 400) begin
      @(posedge clk);
      n++;
    end
    if (inTxn) begin
      chk(0, "R10", 0, 1);
      inTxn = 0;
    end
    repeat (3) @(posedge clk);
    chk(apIdx == expBeats, restart ? "R11" : "R3", apIdx, expBeats);
  endtask

  initial begin
    #(5.0 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int beatList[8] = '{1, 2, 3, 4, 5, 8, 16, 0};
    int t;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(htrans == 2'b00, "R1", htrans, 0);
    chk(reqDone == 1'b0, "R1", reqDone, 0);
    chk(haddr == '0, "R1", haddr, 0);
    chk(hwdata == '0 && rdData == '0, "R1", rdData, 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    t = 0;
    for (int wm = 0; wm < 2; wm++) begin
      waitMode = bit'(wm);
      for (int sz = 0; sz < 3; sz++)
        for (int bu = 0; bu < 2; bu++)
          for (int bi = 0; bi < 8; bi++)
            for (int wr = 0; wr < 2; wr++) begin
              t++;
              runTxn(bit'(wr), AW'(32'h1000 + t * 64), sz, bit'(bu), beatList[bi],
                     DW'(32'hC0DE0000 + t * 32'h1357), 1'b0);
            end
      // R11 restart while busy
      runTxn(1'b1, AW'(32'h8000), 2, 1'b1, 4, 32'hFEEDBEEF, 1'b1);
      runTxn(1'b0, AW'(32'h8100), 1, 1'b0, 3, 32'h0, 1'b1);
      runTxn(1'b0, AW'(32'h8200), 0, 1'b1, 16, 32'h0, 1'b1);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule